// File: doc/BRIEF.md
# Shared-RAM Multi-Queue Transmit FIFO

This block provides a set of independent transmit queues, one per IN endpoint, numbered 0 to NQ-1, all held in one single-port data RAM. Each queue is a circular buffer whose region in the RAM is set at run time by a 32-bit configuration word: the region's first word address sits in bits [15:0] and its length in words sits in bits [31:16]. Queue 0 is configured through a port of its own. Queues 1 to NQ-1 share a second configuration port that carries a queue selector.

The system-bus side pushes words into a chosen queue. The MAC side pops words from a chosen queue. Each queue keeps its own read offset, write offset and word count, and reports full, empty, overflow and underflow flags. Both sides reach the RAM through a fixed-priority arbiter. A pop that will be carried out takes the RAM for that cycle, and the push side is held back through its ready signal. Read data comes out one cycle after the pop is accepted, flagged by `pop_valid`.

The receive region of the same RAM is placed by software, starting at address 0, and is not managed here. Software must lay the transmit regions out so that they do not overlap it or each other.

Top module: `mqf_txq_part`

## Requirements
- R1: After reset every queue has length 0, so all bits of `q_empty` and all bits of `q_full` are 1. All error flags are 0, `pop_valid` is 0 and `push_ready` is 1.
- R2: A configuration write sets the queue's start from word bits [15:0] and its length from bits [31:16]. Queue 0 is written only through `cfg0_we`/`cfg0_word`. Queue k (1..NQ-1) is written through `cfgn_we` with `cfgn_sel`=k; a `cfgn_sel` of 0 is ignored. The write empties that queue and clears its two error flags, starting from the next cycle.
- R3: Words popped from a queue come out in the order they were pushed. `pop_data` is valid, with `pop_valid`=1, in the cycle after the pop is accepted.
- R4: Queues whose regions do not overlap are independent. Pushes and pops on one queue do not change the contents or flags of any other queue.
- R5: A queue of length D holds exactly D words. Its storage addresses run from start to start+D-1 and then wrap back to start, so FIFO order survives any number of wraps.
- R6: `q_empty[q]` is 1 exactly when the queue's count is 0, and `q_full[q]` is 1 exactly when the count equals the length. Both are updated in the cycle after an accepted push or pop.
- R7: A push accepted by the handshake into a full queue is dropped: the contents and the count do not change, and `q_ovf_err[q]` goes to 1 and stays at 1 until that queue is reconfigured.
- R8: A pop from an empty queue is dropped: `pop_valid` stays 0 in the next cycle, and `q_udf_err[q]` goes to 1 and stays at 1 until that queue is reconfigured.
- R9: When `pop_req` targets a non-empty queue, `push_ready` is 0 in that same cycle and no push is taken. In every other cycle `push_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg0_we | input | 1 | Configuration write strobe for queue 0 |
| cfg0_word | input | 32 | Queue 0 configuration: [15:0] start, [31:16] length |
| cfgn_we | input | 1 | Configuration write strobe for queues 1..NQ-1 |
| cfgn_sel | input | QW | Queue selected by `cfgn_we` (0 is ignored) |
| cfgn_word | input | 32 | Configuration for the selected queue: [15:0] start, [31:16] length |
| push_valid | input | 1 | Push request from the bus side |
| push_q | input | QW | Queue targeted by the push |
| push_data | input | DW | Word to push |
| push_ready | output | 1 | Push is taken in the cycles where this and `push_valid` are both 1 |
| pop_req | input | 1 | Pop request from the MAC side |
| pop_q | input | QW | Queue targeted by the pop |
| pop_valid | output | 1 | `pop_data` carries a popped word |
| pop_data | output | DW | Popped word |
| q_full | output | NQ | Per-queue full flag |
| q_empty | output | NQ | Per-queue empty flag |
| q_ovf_err | output | NQ | Per-queue sticky overflow (push to full) flag |
| q_udf_err | output | NQ | Per-queue sticky underflow (pop from empty) flag |

## Verification
A wrong offset or a missed wrap in a queue shows up as a mismatched `pop_data` word at the first pop that reaches the bad address. That is at most one pass around the region after the fault. A wrong count shows up sooner, in the flags: `q_full` or `q_empty` disagrees with the number of words pushed and popped, in the cycle after the access that broke it. A fault in arbitration appears at the ports in the same cycle, as `push_ready` staying high during a legal pop, or as a pushed word missing from the output stream.

// File: rtl/mqf_pkg.sv
package mqf_pkg;
  localparam int FW = 16;  // width of each configuration field

  // Field positions follow the packed member order: length in [31:16], start in [15:0]
  typedef struct packed {
    logic [FW-1:0] depth;
    logic [FW-1:0] start;
  } qcfg_t;
endpackage

// File: rtl/mqf_rst_sync.sv
module mqf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/mqf_qctrl.sv
module mqf_qctrl
  import mqf_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  qcfg_t         cfg_word,
  input  logic          push_acc,
  input  logic          pop_acc,
  input  logic          push_drop,
  input  logic          pop_drop,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          full,
  output logic          empty,
  output logic          ovf_err,
  output logic          udf_err
);
  qcfg_t         cfg_q,  cfg_n;
  logic [FW-1:0] wr_q,   wr_n;
  logic [FW-1:0] rd_q,   rd_n;
  logic [FW-1:0] cnt_q,  cnt_n;
  logic          ovf_q,  ovf_n;
  logic          udf_q,  udf_n;
  logic          en;

  function automatic logic [FW-1:0] step(input logic [FW-1:0] off, input logic [FW-1:0] len);
    return (off == len - FW'(1)) ? '0 : off + FW'(1);
  endfunction

  assign en = cfg_we | push_acc | pop_acc | push_drop | pop_drop;

  always_comb begin
    cfg_n = cfg_q;
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    ovf_n = ovf_q;
    udf_n = udf_q;
    if (cfg_we) begin
      cfg_n = cfg_word;
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
      ovf_n = 1'b0;
      udf_n = 1'b0;
    end else begin
      if (push_acc) begin
        wr_n  = step(wr_q, cfg_q.depth);
        cnt_n = cnt_q + FW'(1);
      end
      if (pop_acc) begin
        rd_n  = step(rd_q, cfg_q.depth);
        cnt_n = cnt_q - FW'(1);
      end
      if (push_drop) ovf_n = 1'b1;
      if (pop_drop)  udf_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else if (en) begin
      cfg_q <= cfg_n;
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
      udf_q <= udf_n;
    end
  end

  assign wr_addr = AW'(cfg_q.start + wr_q);
  assign rd_addr = AW'(cfg_q.start + rd_q);
  assign full    = (cnt_q >= cfg_q.depth);
  assign empty   = (cnt_q == '0);
  assign ovf_err = ovf_q;
  assign udf_err = udf_q;
endmodule

// File: rtl/mqf_arb.sv
module mqf_arb #(
  parameter int NQ = 4,
  parameter int AW = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                   push_valid,
  input  logic [QW-1:0]          push_q,
  input  logic                   pop_req,
  input  logic [QW-1:0]          pop_q,
  input  logic [NQ-1:0]          full,
  input  logic [NQ-1:0]          empty,
  input  logic [NQ-1:0][AW-1:0]  wr_addr,
  input  logic [NQ-1:0][AW-1:0]  rd_addr,
  output logic                   push_ready,
  output logic [NQ-1:0]          push_acc,
  output logic [NQ-1:0]          pop_acc,
  output logic [NQ-1:0]          push_drop,
  output logic [NQ-1:0]          pop_drop,
  output logic                   ram_en,
  output logic                   ram_we,
  output logic [AW-1:0]          ram_addr
);
  logic pop_ok, push_try, push_ok;

  always_comb begin
    pop_ok     = pop_req && !empty[pop_q];
    push_ready = !pop_ok;
    push_try   = push_valid && push_ready;
    push_ok    = push_try && !full[push_q];
    push_acc   = '0;
    pop_acc    = '0;
    push_drop  = '0;
    pop_drop   = '0;
    if (push_ok)              push_acc[push_q]  = 1'b1;
    if (push_try && !push_ok) push_drop[push_q] = 1'b1;
    if (pop_ok)               pop_acc[pop_q]    = 1'b1;
    if (pop_req && !pop_ok)   pop_drop[pop_q]   = 1'b1;
    ram_en   = pop_ok | push_ok;
    ram_we   = push_ok;
    ram_addr = pop_ok ? rd_addr[pop_q] : wr_addr[push_q];
  end
endmodule

// File: rtl/mqf_spram.sv
module mqf_spram #(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/mqf_txq_part.sv
module mqf_txq_part
  import mqf_pkg::*;
#(
  parameter int NQ = 4,
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg0_we,
  input  logic [31:0]   cfg0_word,
  input  logic          cfgn_we,
  input  logic [QW-1:0] cfgn_sel,
  input  logic [31:0]   cfgn_word,
  input  logic          push_valid,
  input  logic [QW-1:0] push_q,
  input  logic [DW-1:0] push_data,
  output logic          push_ready,
  input  logic          pop_req,
  input  logic [QW-1:0] pop_q,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic [NQ-1:0] q_full,
  output logic [NQ-1:0] q_empty,
  output logic [NQ-1:0] q_ovf_err,
  output logic [NQ-1:0] q_udf_err
);
  logic                  rst_sync_n;
  logic [NQ-1:0][AW-1:0] wr_addr, rd_addr;
  logic [NQ-1:0]         push_acc, pop_acc, push_drop, pop_drop;
  logic                  ram_en, ram_we;
  logic [AW-1:0]         ram_addr;

  mqf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic  cfg_hit;
    qcfg_t cfg_sel_word;
    if (i == 0) begin : g_first
      assign cfg_hit      = cfg0_we;
      assign cfg_sel_word = qcfg_t'(cfg0_word);
    end else begin : g_rest
      assign cfg_hit      = cfgn_we && (cfgn_sel == QW'(i));
      assign cfg_sel_word = qcfg_t'(cfgn_word);
    end

    mqf_qctrl #(.AW(AW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cfg_we   (cfg_hit),
      .cfg_word (cfg_sel_word),
      .push_acc (push_acc[i]),
      .pop_acc  (pop_acc[i]),
      .push_drop(push_drop[i]),
      .pop_drop (pop_drop[i]),
      .wr_addr  (wr_addr[i]),
      .rd_addr  (rd_addr[i]),
      .full     (q_full[i]),
      .empty    (q_empty[i]),
      .ovf_err  (q_ovf_err[i]),
      .udf_err  (q_udf_err[i])
    );
  end

  mqf_arb #(.NQ(NQ), .AW(AW)) u_arb (
    .push_valid(push_valid),
    .push_q    (push_q),
    .pop_req   (pop_req),
    .pop_q     (pop_q),
    .full      (q_full),
    .empty     (q_empty),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .push_ready(push_ready),
    .push_acc  (push_acc),
    .pop_acc   (pop_acc),
    .push_drop (push_drop),
    .pop_drop  (pop_drop),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr)
  );

  mqf_spram #(.AW(AW), .DW(DW)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(push_data),
    .rdata(pop_data)
  );

  // Read data is valid in the cycle after an accepted pop
  logic pop_valid_n;
  assign pop_valid_n = |pop_acc;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pop_valid <= 1'b0;
    else             pop_valid <= pop_valid_n;
  end
endmodule

// File: rtl/mqf_txq_part_chk.sv
module mqf_txq_part_chk #(
  parameter int NQ = 4,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg0_we,
  input logic          cfgn_we,
  input logic [QW-1:0] cfgn_sel,
  input logic          push_valid,
  input logic [QW-1:0] push_q,
  input logic          push_ready,
  input logic          pop_req,
  input logic [QW-1:0] pop_q,
  input logic          pop_valid,
  input logic [NQ-1:0] q_full,
  input logic [NQ-1:0] q_empty,
  input logic [NQ-1:0] q_ovf_err,
  input logic [NQ-1:0] q_udf_err
);
  logic cfg_any;
  assign cfg_any = cfg0_we | cfgn_we;

  AST_POP_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !q_empty[pop_q]) |-> !push_ready) else $error("pop priority"); // R9

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_req |-> push_ready) else $error("ready idle"); // R9

  AST_POP_DATA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !q_empty[pop_q]) |=> pop_valid) else $error("pop valid"); // R3

  AST_EMPTY_POP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && q_empty[pop_q] && !cfg_any) |=> (!pop_valid && q_empty[$past(pop_q)] && q_udf_err[$past(pop_q)]))
    else $error("empty pop"); // R8

  AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && q_full[push_q] && !cfg_any) |=> (q_full[$past(push_q)] && q_ovf_err[$past(push_q)]))
    else $error("full push"); // R7

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic cfg_hit;
    if (i == 0) begin : g_first
      assign cfg_hit = cfg0_we;
    end else begin : g_rest
      assign cfg_hit = cfgn_we && (cfgn_sel == QW'(i));
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (q_ovf_err[i] && !cfg_hit) |=> q_ovf_err[i]) else $error("ovf sticky"); // R7

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (q_udf_err[i] && !cfg_hit) |=> q_udf_err[i]) else $error("udf sticky"); // R8

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit |=> (q_empty[i] && !q_ovf_err[i] && !q_udf_err[i])) else $error("cfg clear"); // R2
  end
endmodule

bind mqf_txq_part mqf_txq_part_chk #(.NQ(NQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg0_we   (cfg0_we),
  .cfgn_we   (cfgn_we),
  .cfgn_sel  (cfgn_sel),
  .push_valid(push_valid),
  .push_q    (push_q),
  .push_ready(push_ready),
  .pop_req   (pop_req),
  .pop_q     (pop_q),
  .pop_valid (pop_valid),
  .q_full    (q_full),
  .q_empty   (q_empty),
  .q_ovf_err (q_ovf_err),
  .q_udf_err (q_udf_err)
);

// File: tb/mqf_txq_part_tb.sv
module mqf_txq_part_tb;
  localparam int NQ = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int QW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic          clk;
  logic          rst_n;
  logic          cfg0_we, cfgn_we;
  logic [31:0]   cfg0_word, cfgn_word;
  logic [QW-1:0] cfgn_sel;
  logic          push_valid, push_ready;
  logic [QW-1:0] push_q, pop_q;
  logic [DW-1:0] push_data, pop_data;
  logic          pop_req, pop_valid;
  logic [NQ-1:0] q_full, q_empty, q_ovf_err, q_udf_err;

  mqf_txq_part #(.NQ(NQ), .AW(AW), .DW(DW)) u_dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW-1:0] mq [NQ][$];
  logic [DW-1:0] exp_out [$];
  int  depth_m [NQ];
  bit  ovf_m [NQ];
  bit  udf_m [NQ];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(input int q, input string req);
    chk(q_empty[q] == (mq[q].size() == 0), req, $sformatf("empty q%0d", q), 32'(q_empty[q]), 32'(mq[q].size() == 0));
    chk(q_full[q] == (mq[q].size() >= depth_m[q]), req, $sformatf("full q%0d", q), 32'(q_full[q]), 32'(mq[q].size() >= depth_m[q]));
    chk(q_ovf_err[q] == ovf_m[q], "R7", $sformatf("ovf q%0d", q), 32'(q_ovf_err[q]), 32'(ovf_m[q]));
    chk(q_udf_err[q] == udf_m[q], "R8", $sformatf("udf q%0d", q), 32'(q_udf_err[q]), 32'(udf_m[q]));
  endtask

  // Monitor: compares every popped word against the scoreboard (R3)
  always @(negedge clk) begin
    if (rst_n && pop_valid) begin
      if (exp_out.size() == 0) begin
        chk(1'b0, "R3", "unexpected pop_valid", 32'(pop_data), 32'h0);
      end else begin
        logic [DW-1:0] e;
        e = exp_out.pop_front();
        chk(pop_data == e, "R3", "pop_data order", pop_data, e);
      end
    end
  end

  // Each task starts at a negedge and holds its inputs for exactly one cycle
  task automatic do_cfg(input int q, input int start, input int depth);
    logic [31:0] w;
    w = {16'(depth), 16'(start)};  // R2: length in [31:16], start in [15:0]
    if (q == 0) begin cfg0_we = 1'b1; cfg0_word = w; end
    else begin cfgn_we = 1'b1; cfgn_sel = QW'(q); cfgn_word = w; end
    @(negedge clk);
    cfg0_we = 1'b0; cfgn_we = 1'b0;
    mq[q].delete(); depth_m[q] = depth; ovf_m[q] = 0; udf_m[q] = 0;
    chk_flags(q, "R2");
  endtask

  task automatic do_push(input int q, input logic [DW-1:0] d, input string req);
    bit acc;
    push_valid = 1'b1; push_q = QW'(q); push_data = d;
    #1;
    chk(push_ready == 1'b1, "R9", "push_ready with no pop", 32'(push_ready), 32'h1);
    acc = mq[q].size() < depth_m[q];
    @(negedge clk);
    push_valid = 1'b0;
    if (acc) mq[q].push_back(d); else ovf_m[q] = 1;
    chk_flags(q, req);
  endtask

  task automatic do_pop(input int q, input string req);
    bit has;
    pop_req = 1'b1; pop_q = QW'(q);
    has = mq[q].size() > 0;
    if (has) exp_out.push_back(mq[q].pop_front()); else udf_m[q] = 1;
    @(negedge clk);
    pop_req = 1'b0;
    chk(pop_valid == has, has ? req : "R8", $sformatf("pop_valid q%0d", q), 32'(pop_valid), 32'(has));
    chk_flags(q, req);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg0_we = 0; cfgn_we = 0; cfg0_word = 0; cfgn_word = 0; cfgn_sel = 0;
    push_valid = 0; push_q = 0; push_data = 0; pop_req = 0; pop_q = 0;
    for (int i = 0; i < NQ; i++) begin depth_m[i] = 0; ovf_m[i] = 0; udf_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(q_empty == '1, "R1", "q_empty", 32'(q_empty), 32'hF);
    chk(q_full == '1, "R1", "q_full", 32'(q_full), 32'hF);
    chk(q_ovf_err == '0 && q_udf_err == '0, "R1", "errors", 32'({q_ovf_err, q_udf_err}), 32'h0);
    chk(pop_valid == 1'b0, "R1", "pop_valid", 32'(pop_valid), 32'h0);
    chk(push_ready == 1'b1, "R1", "push_ready", 32'(push_ready), 32'h1);

    // R2: configure four disjoint regions
    do_cfg(0, 16'h10, 4);
    do_cfg(1, 16'h20, 3);
    do_cfg(2, 16'h30, 5);
    do_cfg(3, 16'h40, 2);

    // R3/R6: basic order on queue 0
    do_push(0, 32'hA000_0001, "R6");
    do_push(0, 32'hA000_0002, "R6");
    do_push(0, 32'hA000_0003, "R6");
    do_pop(0, "R3"); do_pop(0, "R3"); do_pop(0, "R6");

    // R4: interleaved traffic on several queues
    do_push(1, 32'hB100_0001, "R4");
    do_push(2, 32'hB200_0001, "R4");
    do_push(0, 32'hB000_0001, "R4");
    do_push(2, 32'hB200_0002, "R4");
    do_pop(2, "R4"); do_pop(1, "R4"); do_push(1, 32'hB100_0002, "R4");
    do_pop(0, "R4"); do_pop(2, "R4"); do_pop(1, "R4");

    // R5: fill to exact length, then wrap several times on queue 1 (length 3)
    do_push(1, 32'hC000_0000, "R5");
    do_push(1, 32'hC000_0001, "R5");
    do_push(1, 32'hC000_0002, "R5");
    for (int r = 0; r < 5; r++) begin
      do_pop(1, "R5"); do_pop(1, "R5");
      do_push(1, 32'hC100_0000 + 32'(r), "R5");
      do_push(1, 32'hC200_0000 + 32'(r), "R5");
    end
    do_pop(1, "R5"); do_pop(1, "R5"); do_pop(1, "R5");

    // R7: overflow on queue 3 (length 2)
    do_push(3, 32'hD000_0001, "R6");
    do_push(3, 32'hD000_0002, "R6");
    do_push(3, 32'hDEAD_DEAD, "R7");
    do_push(0, 32'hD0D0_0000, "R7");
    do_pop(0, "R7");
    chk(q_ovf_err[3] == 1'b1, "R7", "ovf sticky q3", 32'(q_ovf_err[3]), 32'h1);
    do_pop(3, "R7"); do_pop(3, "R7");

    // R8: underflow on queue 2
    do_pop(2, "R8");
    do_push(2, 32'hE000_0001, "R8");
    chk(q_udf_err[2] == 1'b1, "R8", "udf sticky q2", 32'(q_udf_err[2]), 32'h1);
    do_pop(2, "R8");

    // R9: push and pop in the same cycle, pop wins
    do_push(0, 32'hF000_0001, "R9");
    push_valid = 1'b1; push_q = 2'd1; push_data = 32'hF100_0001;
    pop_req = 1'b1; pop_q = 2'd0;
    exp_out.push_back(mq[0].pop_front());
    #1;
    chk(push_ready == 1'b0, "R9", "push_ready during pop", 32'(push_ready), 32'h0);
    @(negedge clk);
    pop_req = 1'b0;
    #1;
    chk(push_ready == 1'b1, "R9", "push_ready after pop", 32'(push_ready), 32'h1);
    chk(q_empty[1] == 1'b1, "R9", "stalled push not taken", 32'(q_empty[1]), 32'h1);
    @(negedge clk);
    push_valid = 1'b0;
    mq[1].push_back(32'hF100_0001);
    chk_flags(1, "R9");
    chk_flags(0, "R9");
    do_pop(1, "R9");

    // R2: sel 0 on the shared port leaves queue 0 alone; reconfig clears errors
    do_push(0, 32'h1234_0001, "R2");
    cfgn_we = 1'b1; cfgn_sel = 2'd0; cfgn_word = {16'd1, 16'h80};
    @(negedge clk);
    cfgn_we = 1'b0;
    chk_flags(0, "R2");
    do_pop(0, "R2");
    chk(q_ovf_err[3] == 1'b1, "R7", "ovf before reconfig", 32'(q_ovf_err[3]), 32'h1);
    do_cfg(3, 16'h40, 2);
    do_cfg(2, 16'h30, 5);

    repeat (3) @(negedge clk);
    chk(exp_out.size() == 0, "R3", "pending pops", 32'(exp_out.size()), 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule